// File: doc/BRIEF.md
# Hash Engine Register Controller

This block is the bus-facing side of a hash accelerator. Software reaches it through word writes and reads on a small address map. A control word holds the command bits, the interrupt enables, the algorithm select, the read-out byte order and the input-window mode. A length word reports how many message bytes the last finished hash consumed. An eight-word window exposes the chaining state. A 64-byte window accepts message data. The compression rounds live in a separate core. This block reaches that core through a start pulse, a 512-bit block, a 256-bit state in, a done strobe and a 256-bit state out.

Message words fill a sixteen-word buffer in the order they arrive, whatever offset inside the window is used. A full buffer launches a compression on its own. While that compression runs, further data writes are held off through a ready signal. A final command pads the pending words using the running byte count, sends one or two last blocks, then clears the command bits and raises the enabled interrupts. The chaining state window can be read and written between blocks, so a hash can be saved and resumed later.

Top module: `hash_ctl`

## Requirements
- R1: After reset the control word (offset 0x00) and the length word (offset 0x04) read zero, both interrupt outputs are low, and `bus_ready` is high.
- R2: Writing the control word with bit 0 set and bit 1 clear, while the engine is idle and no bytes are pending, loads the initial chaining values. Bits 5:4 select them: 0 gives the SHA-256 values, 1 the SHA-224 values, and 2 or 3 the SHA-1 values with words 5 to 7 zero.
- R3: Each write to any offset in 0x80..0xBF appends one word to the block buffer. The sixteenth word launches a compression with a one-cycle `core_start`, and the first word written occupies `core_block[511:480]`.
- R4: While a compression runs, or while the buffer holds sixteen words, writes to the input window see `bus_ready` low. They are accepted after the core reports done.
- R5: Setting control bit 1 with at most 13 words pending sends one block. That block holds the pending words, then 0x80000000, then zeros, with the message length in bits in words 14 (upper half) and 15 (lower half).
- R6: With 14 or 15 words pending, the final command sends two blocks. The first block holds the data, the 0x80000000 marker and zero fill. The second block is zero except for the bit length in words 14 and 15.
- R7: The length word reads the total byte count of the finished message. It changes only when a final command completes.
- R8: When the final command completes, control bits 0 and 1 read zero. `irq_a` pulses for one cycle if control bit 2 is set, and `irq_b` pulses for one cycle if control bit 10 is set.
- R9: A read at 0x40+4k returns chaining word k. The word is returned unchanged when control bit 3 is 1, and byte-reversed when bit 3 is 0.
- R10: With SHA-224 selected, word 7 of the digest window reads zero. With SHA-1 selected, words 5 to 7 read zero.
- R11: A write at 0x40+4k while idle replaces chaining word k, and the next compression receives the replaced state on `core_state_in`.
- R12: A read in the input window returns the number of buffered words when control bit 9 is 1, and zero when bit 9 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, held until accepted |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| bus_ready | output | 1 | Low while an input-window write must wait |
| irq_a | output | 1 | Completion pulse, gated by control bit 2 |
| irq_b | output | 1 | Completion pulse, gated by control bit 10 |
| core_start | output | 1 | One-cycle launch of a compression |
| core_block | output | 512 | Block for the core, first word in the top bits |
| core_state_in | output | 256 | Chaining state for the core, word 0 in the top bits |
| core_done | input | 1 | Core finished; `core_state_out` valid |
| core_state_out | input | 256 | New chaining state from the core |

## Verification
The hardest case to reach is the two-block final, where 14 or 15 words are pending. It takes a marker-only block followed by a length-only block, with a second launch that the controller issues on its own straight after the first done. The bench reaches it with a SHA-1 hash of 14 words, and again with a restored state and 15 words. A scoreboard queue holds every block the requirements predict, so both launches are compared word by word. The stall case is forced by writing a seventeenth word immediately after the sixteenth, while the model core is still counting.

// File: rtl/hash_ctl_pkg.sv
package hash_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BLK   = 3'd1,
        PH_P1    = 3'd2,
        PH_P2GO  = 3'd3,
        PH_P2    = 3'd4
    } phase_e;

    typedef struct packed {
        logic       ie_b;
        logic       fifo;
        logic [1:0] alg;
        logic       big;
        logic       ie_a;
        logic       fin;
        logic       go;
    } ctl_t;

    typedef logic [0:7][31:0] hstate_t;

    function automatic hstate_t iv_of(input logic [1:0] sel);
        case (sel)
            2'd0: return {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                          32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
            2'd1: return {32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
                          32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};
            default: return {32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476,
                             32'hc3d2e1f0, 32'h0, 32'h0, 32'h0};
        endcase
    endfunction

endpackage

// File: rtl/hash_ctl_blkbuf.sv
module hash_ctl_blkbuf #(
    parameter int N  = 16,
    parameter int W  = 32,
    parameter int CW = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             clear,
    output logic [N*W-1:0]   words,
    output logic [CW-1:0]    cnt,
    output logic             full
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [0:N-1][W-1:0] w;
        logic [CW-1:0]       cnt;
    } bq_t;

    bq_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (clear) begin
            q_d.cnt = '0;
        end else if (push) begin
            q_d.w[q_q.cnt[IW-1:0]] = din;
            q_d.cnt = q_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign words = q_q.w;
    assign cnt   = q_q.cnt;
    assign full  = (q_q.cnt == CW'(N));

    // R4
    buf_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (q_q.cnt < CW'(N)));

endmodule

// File: rtl/hash_ctl_pad.sv
module hash_ctl_pad #(
    parameter int N  = 16,
    parameter int W  = 32,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N*W-1:0] words,
    input  logic [CW-1:0]  cnt,
    input  logic [2*W-1:0] bitlen,
    output logic [N*W-1:0] blk1,
    output logic [N*W-1:0] blk2,
    output logic           two
);
    localparam logic [W-1:0] MARK = W'(8'h80) << (W - 8);

    logic [0:N-1][W-1:0] wv, b1, b2;

    assign wv  = words;
    assign two = (cnt > CW'(N - 3));

    for (genvar i = 0; i < N; i++) begin : g_word
        logic [W-1:0] body;
        always_comb begin
            if (CW'(i) < cnt)       body = wv[i];
            else if (CW'(i) == cnt) body = MARK;
            else                    body = '0;
        end
        if (i == N - 2) begin : g_hi
            assign b1[i] = two ? body : bitlen[2*W-1:W];
            assign b2[i] = bitlen[2*W-1:W];
        end else if (i == N - 1) begin : g_lo
            assign b1[i] = two ? body : bitlen[W-1:0];
            assign b2[i] = bitlen[W-1:0];
        end else begin : g_mid
            assign b1[i] = body;
            assign b2[i] = '0;
        end
    end

    assign blk1 = b1;
    assign blk2 = b2;

endmodule

// File: rtl/hash_ctl_view.sv
module hash_ctl_view #(
    parameter int W  = 32,
    parameter int S  = 8,
    parameter int IW = $clog2(S)
) (
    input  logic [S*W-1:0] st,
    input  logic [IW-1:0]  idx,
    input  logic [1:0]     alg,
    input  logic           big,
    output logic [W-1:0]   word
);
    logic [0:S-1][W-1:0] sv;
    logic [IW:0]         lim;
    logic [W-1:0]        raw;

    assign sv = st;

    always_comb begin
        unique case (alg)
            2'd0:    lim = (IW+1)'(S);
            2'd1:    lim = (IW+1)'(S - 1);
            default: lim = (IW+1)'(5);
        endcase
        raw  = ({1'b0, idx} < lim) ? sv[idx] : '0;
        word = big ? raw : {<<8{raw}};
    end

endmodule

// File: rtl/hash_ctl.sv
module hash_ctl #(
    parameter int BLK_WORDS = 16,
    parameter int LEN_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_ready,
    output logic                    irq_a,
    output logic                    irq_b,
    output logic                    core_start,
    output logic [BLK_WORDS*32-1:0] core_block,
    output logic [255:0]            core_state_in,
    input  logic                    core_done,
    input  logic [255:0]            core_state_out
);
    import hash_ctl_pkg::*;

    localparam int W  = 32;
    localparam int CW = $clog2(BLK_WORDS + 1);

    typedef struct packed {
        ctl_t             ctl;
        phase_e           ph;
        hstate_t          hst;
        logic [LEN_W-1:0] bytes;
        logic [LEN_W-1:0] blkcnt;
        logic             irq_a;
        logic             irq_b;
    } regs_t;

    regs_t r_q, r_d;

    logic                    in_win, dg_win, ctl_wr, dg_wr, idle, push, buf_clr;
    logic                    full, two, launch_fin;
    logic [CW-1:0]           buf_cnt;
    logic [BLK_WORDS*W-1:0]  buf_words, pad1, pad2;
    logic [W-1:0]            view_word;

    assign in_win     = (bus_addr[7:6] == 2'b10);
    assign dg_win     = (bus_addr[7:5] == 3'b010);
    assign ctl_wr     = bus_wr && (bus_addr == 8'h00);
    assign dg_wr      = bus_wr && dg_win;
    assign idle       = (r_q.ph == PH_IDLE);
    assign bus_ready  = !(in_win && (!idle || full));
    assign push       = bus_wr && in_win && bus_ready;
    assign launch_fin = idle && !full && r_q.ctl.fin;

    hash_ctl_blkbuf #(.N(BLK_WORDS), .W(W)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .din(bus_wdata), .clear(buf_clr),
        .words(buf_words), .cnt(buf_cnt), .full(full)
    );

    hash_ctl_pad #(.N(BLK_WORDS), .W(W)) u_pad (
        .words(buf_words), .cnt(buf_cnt),
        .bitlen((2*W)'({r_q.bytes, 3'b000})),
        .blk1(pad1), .blk2(pad2), .two(two)
    );

    hash_ctl_view #(.W(W), .S(8)) u_view (
        .st(r_q.hst), .idx(bus_addr[4:2]), .alg(r_q.ctl.alg),
        .big(r_q.ctl.big), .word(view_word)
    );

    always_comb begin
        logic finish;
        finish  = 1'b0;
        buf_clr = 1'b0;
        r_d       = r_q;
        r_d.irq_a = 1'b0;
        r_d.irq_b = 1'b0;
        if (push) r_d.bytes = r_q.bytes + LEN_W'(4);
        if (ctl_wr) begin
            r_d.ctl.ie_b = bus_wdata[10];
            r_d.ctl.fifo = bus_wdata[9];
            r_d.ctl.alg  = bus_wdata[5:4];
            r_d.ctl.big  = bus_wdata[3];
            r_d.ctl.ie_a = bus_wdata[2];
            r_d.ctl.go   = r_q.ctl.go  | bus_wdata[0];
            r_d.ctl.fin  = r_q.ctl.fin | bus_wdata[1];
            if (bus_wdata[0] && !bus_wdata[1] && r_q.bytes == '0 && idle)
                r_d.hst = iv_of(bus_wdata[5:4]);
        end
        if (dg_wr && idle) r_d.hst[bus_addr[4:2]] = bus_wdata;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (full)            r_d.ph = PH_BLK;
                else if (r_q.ctl.fin) r_d.ph = PH_P1;
            end
            PH_BLK: if (core_done) begin
                r_d.hst = core_state_out;
                buf_clr = 1'b1;
                r_d.ph  = PH_IDLE;
            end
            PH_P1: if (core_done) begin
                r_d.hst = core_state_out;
                if (two) r_d.ph = PH_P2GO;
                else     finish = 1'b1;
            end
            PH_P2GO: r_d.ph = PH_P2;
            PH_P2: if (core_done) begin
                r_d.hst = core_state_out;
                finish  = 1'b1;
            end
            default: r_d.ph = PH_IDLE;
        endcase
        if (finish) begin
            buf_clr     = 1'b1;
            r_d.ph      = PH_IDLE;
            r_d.blkcnt  = r_q.bytes;
            r_d.bytes   = '0;
            r_d.ctl.go  = 1'b0;
            r_d.ctl.fin = 1'b0;
            r_d.irq_a   = r_q.ctl.ie_a;
            r_d.irq_b   = r_q.ctl.ie_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign core_start    = (idle && (full || r_q.ctl.fin)) || (r_q.ph == PH_P2GO);
    assign core_state_in = r_q.hst;
    assign irq_a         = r_q.irq_a;
    assign irq_b         = r_q.irq_b;

    always_comb begin
        if (launch_fin || r_q.ph == PH_P1)             core_block = pad1;
        else if (r_q.ph == PH_P2GO || r_q.ph == PH_P2) core_block = pad2;
        else                                           core_block = buf_words;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == 8'h00)
            bus_rdata = {21'b0, r_q.ctl.ie_b, r_q.ctl.fifo, 3'b000, r_q.ctl.alg,
                         r_q.ctl.big, r_q.ctl.ie_a, r_q.ctl.fin, r_q.ctl.go};
        else if (bus_addr == 8'h04) bus_rdata = 32'(r_q.blkcnt);
        else if (dg_win)            bus_rdata = view_word;
        else if (in_win && r_q.ctl.fifo) bus_rdata = 32'(buf_cnt);
    end

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R4
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_BLK && !core_done) |=> (buf_cnt == $past(buf_cnt)));

    // R8
    irq_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a || irq_b) |-> (!r_q.ctl.fin && !r_q.ctl.go));

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_IDLE && $past(r_q.ph) == PH_IDLE) |-> $stable(r_q.blkcnt));

endmodule

// File: tb/hash_ctl_bench.sv
`timescale 1ns/1ps
module hash_ctl_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h0;
    logic [31:0]  bus_wdata = 32'h0;
    logic [31:0]  bus_rdata;
    logic         bus_ready, irq_a, irq_b, core_start;
    logic [511:0] core_block;
    logic [255:0] core_state_in;
    logic         core_done = 1'b0;
    logic [255:0] core_state_out = '0;

    int n_tests = 0, n_fail = 0, ia_cnt = 0, ib_cnt = 0;
    logic [511:0] exp_q[$];
    logic [31:0]  pend[$];
    logic [31:0]  exp_st[8];
    int           total_bytes = 0;
    logic [1:0]   cur_alg = 2'd0;
    logic         cur_big = 1'b0;

    always #4 clk = ~clk;

    hash_ctl u_hash_ctl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .irq_a(irq_a), .irq_b(irq_b), .core_start(core_start),
        .core_block(core_block), .core_state_in(core_state_in),
        .core_done(core_done), .core_state_out(core_state_out)
    );

    task automatic chk(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] core_fn(input logic [255:0] s, input logic [511:0] b);
        logic [255:0] r;
        for (int j = 0; j < 8; j++)
            r[255-32*j -: 32] = (s[255-32*j -: 32] ^ b[511-32*j -: 32])
                                + b[511-32*(j+8) -: 32] + 32'(j);
        return r;
    endfunction

    always @(negedge clk) begin
        if (irq_a) ia_cnt++;
        if (irq_b) ib_cnt++;
    end

    // model core plus scoreboard monitor
    initial begin
        logic [511:0] blk, e;
        logic [255:0] st;
        forever begin
            @(negedge clk);
            core_done = 1'b0;
            if (core_start) begin
                blk = core_block;
                st  = core_state_in;
                if (exp_q.size() == 0) chk(1'b0, "R3 unexpected block", blk, '0);
                else begin
                    e = exp_q.pop_front();
                    chk(blk == e, "R3/R5/R6/R11 block content", blk, e);
                end
                repeat (3) @(negedge clk);
                core_state_out = core_fn(st, blk);
                core_done = 1'b1;
            end
        end
    end

    function automatic logic [511:0] pack16(input logic [31:0] a[16]);
        logic [511:0] r;
        for (int j = 0; j < 16; j++) r[511-32*j -: 32] = a[j];
        return r;
    endfunction

    task automatic expect_blk(input logic [31:0] a[16]);
        logic [511:0] b;
        logic [255:0] s, n;
        b = pack16(a);
        exp_q.push_back(b);
        for (int j = 0; j < 8; j++) s[255-32*j -: 32] = exp_st[j];
        n = core_fn(s, b);
        for (int j = 0; j < 8; j++) exp_st[j] = n[255-32*j -: 32];
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d, output bit waited);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; waited = 1'b0;
        #1;
        while (!bus_ready) begin waited = 1'b1; @(negedge clk); #1; end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wctl(input logic [31:0] v);
        bit w;
        cur_alg = v[5:4]; cur_big = v[3];
        bw(8'h00, v, w);
    endtask

    task automatic push_word(input int i, input logic [31:0] d, output bit waited);
        logic [31:0] a[16];
        pend.push_back(d);
        total_bytes += 4;
        if (pend.size() == 16) begin
            for (int j = 0; j < 16; j++) a[j] = pend[j];
            expect_blk(a);
            pend.delete();
        end
        bw(8'h80 + 8'(((i * 5) % 16) * 4), d, waited);
    endtask

    task automatic push_n(input int n, input logic [31:0] seed);
        bit w;
        for (int i = 0; i < n; i++) push_word(i, seed + 32'(i * 32'h01010101), w);
    endtask

    function automatic logic [31:0] exp_rd(input int k);
        logic [31:0] v;
        int lim;
        lim = (cur_alg == 2'd0) ? 8 : (cur_alg == 2'd1) ? 7 : 5;
        v = (k < lim) ? exp_st[k] : 32'h0;
        return cur_big ? v : {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic dchk(input int k, input string req);
        logic [31:0] d;
        br(8'h40 + 8'(4 * k), d);
        chk(d == exp_rd(k), req, d, exp_rd(k));
    endtask

    task automatic do_final(input logic [31:0] ctlv);
        logic [31:0] a[16], b[16], c;
        logic [63:0] bl;
        int n, blen, t;
        n = pend.size();
        bl = 64'(total_bytes) * 8;
        for (int j = 0; j < 16; j++) begin a[j] = 32'h0; b[j] = 32'h0; end
        for (int j = 0; j < n; j++) a[j] = pend[j];
        a[n] = 32'h8000_0000;
        if (n <= 13) begin
            a[14] = bl[63:32]; a[15] = bl[31:0];
            expect_blk(a);
        end else begin
            expect_blk(a);
            b[14] = bl[63:32]; b[15] = bl[31:0];
            expect_blk(b);
        end
        blen = total_bytes;
        pend.delete();
        total_bytes = 0;
        wctl(ctlv | 32'h2);
        for (t = 0; t < 200; t++) begin
            br(8'h00, c);
            if (c[1:0] == 2'b00) break;
        end
        chk(c[1:0] == 2'b00, "R8 start/final bits clear", c, '0);
        br(8'h04, c);
        chk(c == 32'(blen), "R7 length word", c, blen);
        chk(exp_q.size() == 0, "R5/R6 all blocks sent", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit w;
        for (int j = 0; j < 8; j++) exp_st[j] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        br(8'h00, d); chk(d == 0, "R1 control reset", d, 0);
        br(8'h04, d); chk(d == 0, "R1 length reset", d, 0);
        chk(!irq_a && !irq_b, "R1 irq low", {irq_a, irq_b}, 0);
        chk(bus_ready, "R1 ready high", bus_ready, 1);

        // R2 SHA-256 initial values, both interrupt enables, big order
        wctl(32'h40D);
        exp_st = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                   32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
        dchk(0, "R2 sha256 word0");
        dchk(7, "R2 sha256 word7");

        // R3 full block, R4 stall on the 17th word
        for (int i = 0; i < 16; i++) push_word(i, 32'hA000_0000 + 32'(i), w);
        push_word(16, 32'hB000_0000, w);
        chk(w, "R4 write stalled while busy", w, 1);
        push_word(17, 32'hB000_0001, w);
        chk(!w, "R4 write accepted when idle", w, 0);
        push_word(18, 32'hB000_0002, w);

        // R5 single-block final, R7 length 76, R8 interrupts
        do_final(32'h40C);
        chk(ia_cnt == 1, "R8 irq_a pulse", ia_cnt, 1);
        chk(ib_cnt == 1, "R8 irq_b pulse", ib_cnt, 1);
        for (int k = 0; k < 8; k++) dchk(k, "R9 big-endian read");
        wctl(32'h404);
        dchk(0, "R9 little-endian read");
        dchk(5, "R9 little-endian read");

        // R2 SHA-1 values, R10 masking, R6 two-block final
        wctl(32'h29);
        exp_st = '{32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476,
                   32'hc3d2e1f0, 32'h0, 32'h0, 32'h0};
        dchk(4, "R2 sha1 word4");
        dchk(5, "R10 sha1 word5 zero");
        push_n(14, 32'h1111_0000);
        do_final(32'h28);
        chk(ia_cnt == 1 && ib_cnt == 1, "R8 irq disabled", {ia_cnt, ib_cnt}, {32'd1, 32'd1});
        for (int k = 0; k < 8; k++) dchk(k, "R10 sha1 digest view");

        // R2 mode 3 also SHA-1; R5 empty message
        wctl(32'h39);
        exp_st = '{32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476,
                   32'hc3d2e1f0, 32'h0, 32'h0, 32'h0};
        dchk(0, "R2 mode3 word0");
        do_final(32'h38);
        dchk(2, "R5 empty message digest");

        // R2 SHA-224, R10 word 7 hidden
        wctl(32'h19);
        exp_st = '{32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
                   32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};
        dchk(6, "R2 sha224 word6");
        dchk(7, "R10 sha224 word7 zero");

        // R11 restore state, then 15 words (R6)
        for (int k = 0; k < 8; k++) begin
            bw(8'h40 + 8'(4 * k), 32'h1000_0000 + 32'(k * 3), w);
            exp_st[k] = 32'h1000_0000 + 32'(k * 3);
        end
        dchk(3, "R11 restored word3");
        push_n(15, 32'h2222_0000);
        do_final(32'h18);
        for (int k = 0; k < 7; k++) dchk(k, "R11 digest after restore");

        // R12 input-window read in both modes
        wctl(32'h208);
        push_n(5, 32'h3333_0000);
        br(8'h80, d); chk(d == 5, "R12 fill level", d, 5);
        br(8'hBC, d); chk(d == 5, "R12 fill level any offset", d, 5);
        wctl(32'h008);
        br(8'h80, d); chk(d == 0, "R12 write-only reads zero", d, 0);
        do_final(32'h008);
        dchk(7, "R5 digest after fifo-mode hash");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule